// File: doc/BRIEF.md
# Dual-Issue Structural Hazard Checker

The checker sits at the issue stage of a small in-order core that can start two instructions per cycle. In every cycle it is shown up to two candidates in program order. Each candidate carries an operation class, a width flag (32/64-bit for integer work, single/double for floating work), two source register numbers and an optional destination. From these it decides which candidates start this cycle.

The decision rests on the resources each class needs. There are two generic issue slots and a memory pipe. The arithmetic pipe has an integer half and a float half, and only one half can be used in a cycle. An integer multiply/divide unit and a float divide/square-root unit stay occupied for many cycles. A double-precision multiply also keeps the float half for three cycles.

A per-register countdown scoreboard holds back any candidate whose sources are still being produced. The result is returned as a two-bit issue vector. The instruction buffer uses that vector to advance by zero, one or two entries.

Top module: `hz_dual_issue_checker`

## Requirements
- R1: Class codes on `class_i` are: 0 int-alu/shift/slt/clz/const/nop/trap, 1 int cond-move, 2 branch/jump/call, 3 load, 4 store, 5 reg-transfer, 6 float cond-move, 7 int multiply/mul-add, 8 int divide, 9 move-from-hi/lo, 10 move-to-hi/lo, 11 float abs/neg/cmp/move, 12 float add/convert, 13 float multiply/mul-add, 14 float div/recip/sqrt/rsqrt, 15 unknown/multi. `dbl_i`=1 selects 64-bit or double. Classes 0, 1 and 2 use a generic slot, so two of them may issue together.
- R2: Classes 3, 4, 5 and 6 need the single memory pipe. At most one of them issues per cycle.
- R3: Classes 7 to 10 use the integer half of the arithmetic pipe, and classes 11 to 14 use the float half. Two candidates that both need any half of that pipe never issue in the same cycle.
- R4: Candidate 1 issues only when candidate 0 issues in the same cycle. Candidate 0 wins any contested resource.
- R5: A 64-bit multiply occupies the integer multiply/divide unit for 7 cycles. A divide occupies it for 38 cycles (32-bit) or 70 cycles (64-bit). Starting at the issue cycle, no 64-bit multiply or divide can issue during that span. A 32-bit multiply is not held back by it.
- R6: Class 14 occupies the float divide unit for 22 cycles (single) or 37 cycles (double), starting at its issue cycle. No other class 14 can issue during that span.
- R7: A double class-13 operation holds the float half for 3 cycles: its issue cycle and the two that follow. In the two following cycles, no class 7 to 14 can issue.
- R8: Class 15 takes both generic slots, the memory pipe and the integer half, so it always issues alone.
- R9: Result latency is: class 0 → 1; class 1 → 2; class 2 → 2; class 3 → 3; class 4 → 1; class 5 → 2; class 6 → 2; class 7 → 3 or 7; class 8 → 38 or 70; class 9 → 1; class 10 → 5; class 11 → 2; class 12 → 6; class 13 → 6 or 9; class 14 → 22 or 37; class 15 → 1. A candidate that reads a register written by an instruction issued L cycles earlier (with that latency L) may issue at the earliest L cycles after its producer.
- R10: Candidate 1 does not issue if it reads the destination that candidate 0 writes in the same cycle.
- R11: Reset (`rst_ni` low) clears every unit counter and scoreboard entry. After reset, any candidate pair that fits the slot rules issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 2 | Candidate present, bit 0 is older |
| class_i | input | 2x4 | Operation class per candidate |
| dbl_i | input | 2 | 64-bit / double-precision flag |
| rs1_i | input | 2xAW | First source register |
| rs2_i | input | 2xAW | Second source register |
| rd_i | input | 2xAW | Destination register |
| rd_we_i | input | 2 | Destination is written |
| issue_o | output | 2 | Candidates issued this cycle |

## Verification
The delicate overlaps come from resource conflicts and data hazards landing in the same cycle. One case is a busy unit releasing in exactly the cycle where the younger candidate also contends for the arithmetic pipe. Another is a scoreboard stall on candidate 0 hiding a clash that candidate 1 would otherwise lose. Random pairs drawn from a pool of eight registers, with long divides in the mix, make these collisions frequent. Each cycle's issue vector is compared with a cycle-accurate bench model. Directed sequences then probe the exact release cycle of every unit and the first legal cycle for a dependent instruction.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int LAT_W = 7;

  typedef enum logic [3:0] {
    CL_INT = 4'd0, CL_ICMOV = 4'd1, CL_BR = 4'd2, CL_LD = 4'd3,
    CL_ST = 4'd4, CL_XFER = 4'd5, CL_FCMOV = 4'd6, CL_IMUL = 4'd7,
    CL_IDIV = 4'd8, CL_MFHL = 4'd9, CL_MTHL = 4'd10, CL_FQUICK = 4'd11,
    CL_FADD = 4'd12, CL_FMUL = 4'd13, CL_FDIV = 4'd14, CL_UNK = 4'd15
  } cls_e;

  typedef struct packed {
    logic [1:0]       any_n;  // generic slots taken
    logic             m;
    logic             fi;
    logic             ff;
    logic             imul;
    logic             fdiv;
    logic             fhold;
    logic [LAT_W-1:0] lat;
    logic [LAT_W-1:0] occ;    // unit occupancy, cycles
  } claim_t;
endpackage

// File: rtl/hz_decode.sv
module hz_decode
  import hz_pkg::*;
(
  input  logic [3:0] class_i,
  input  logic       dbl_i,
  output claim_t     claim_o
);
  always_comb begin
    claim_o = '0;
    unique case (cls_e'(class_i))
      CL_INT:    begin claim_o.any_n = 2'd1; claim_o.lat = 7'd1; end
      CL_ICMOV:  begin claim_o.any_n = 2'd1; claim_o.lat = 7'd2; end
      CL_BR:     begin claim_o.any_n = 2'd1; claim_o.lat = 7'd2; end
      CL_LD:     begin claim_o.m = 1'b1; claim_o.lat = 7'd3; end
      CL_ST:     begin claim_o.m = 1'b1; claim_o.lat = 7'd1; end
      CL_XFER:   begin claim_o.m = 1'b1; claim_o.lat = 7'd2; end
      CL_FCMOV:  begin claim_o.m = 1'b1; claim_o.lat = 7'd2; end
      CL_IMUL: begin
        claim_o.fi   = 1'b1;
        claim_o.imul = dbl_i;
        claim_o.lat  = dbl_i ? 7'd7 : 7'd3;
        claim_o.occ  = dbl_i ? 7'd7 : 7'd0;
      end
      CL_IDIV: begin
        claim_o.fi   = 1'b1;
        claim_o.imul = 1'b1;
        claim_o.lat  = dbl_i ? 7'd70 : 7'd38;
        claim_o.occ  = claim_o.lat;
      end
      CL_MFHL:   begin claim_o.fi = 1'b1; claim_o.lat = 7'd1; end
      CL_MTHL:   begin claim_o.fi = 1'b1; claim_o.lat = 7'd5; end
      CL_FQUICK: begin claim_o.ff = 1'b1; claim_o.lat = 7'd2; end
      CL_FADD:   begin claim_o.ff = 1'b1; claim_o.lat = 7'd6; end
      CL_FMUL: begin
        claim_o.ff    = 1'b1;
        claim_o.fhold = dbl_i;
        claim_o.lat   = dbl_i ? 7'd9 : 7'd6;
        claim_o.occ   = dbl_i ? 7'd3 : 7'd0;
      end
      CL_FDIV: begin
        claim_o.ff   = 1'b1;
        claim_o.fdiv = 1'b1;
        claim_o.lat  = dbl_i ? 7'd37 : 7'd22;
        claim_o.occ  = claim_o.lat;
      end
      default: begin
        claim_o.any_n = 2'd2;
        claim_o.m     = 1'b1;
        claim_o.fi    = 1'b1;
        claim_o.lat   = 7'd1;
      end
    endcase
  end
endmodule

// File: rtl/hz_busy_ctr.sv
module hz_busy_ctr #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_CTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_CTR_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> cnt_q == '0); // R5
endmodule

// File: rtl/hz_scoreboard.sv
module hz_scoreboard #(
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG),
  parameter int LW   = 7,
  parameter int NWR  = 2,
  parameter int NRD  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NWR-1:0]          wr_en_i,
  input  logic [NWR-1:0][AW-1:0]  wr_addr_i,
  input  logic [NWR-1:0][LW-1:0]  wr_lat_i,
  input  logic [NRD-1:0][AW-1:0]  rd_addr_i,
  output logic [NRD-1:0]          rd_busy_o
);
  logic [NREG-1:0][LW-1:0] cnt_q;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic          hit;
    logic [LW-1:0] nxt;
    // younger write wins
    always_comb begin
      hit = 1'b0;
      nxt = '0;
      for (int w = 0; w < NWR; w++) begin
        if (wr_en_i[w] && wr_addr_i[w] == AW'(r)) begin
          hit = 1'b1;
          nxt = wr_lat_i[w] - 1'b1;
        end
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               cnt_q[r] <= '0;
      else if (hit)              cnt_q[r] <= nxt;
      else if (cnt_q[r] != '0)   cnt_q[r] <= cnt_q[r] - 1'b1;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_busy_o[p] = (cnt_q[rd_addr_i[p]] != '0);
  end
endmodule

// File: rtl/hz_dual_issue_checker.sv
module hz_dual_issue_checker
  import hz_pkg::*;
#(
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          valid_i,
  input  logic [1:0][3:0]     class_i,
  input  logic [1:0]          dbl_i,
  input  logic [1:0][AW-1:0]  rs1_i,
  input  logic [1:0][AW-1:0]  rs2_i,
  input  logic [1:0][AW-1:0]  rd_i,
  input  logic [1:0]          rd_we_i,
  output logic [1:0]          issue_o
);
  claim_t [1:0] cl;
  logic   [1:0] unit_ok, raw, f_req;
  logic   [3:0] rd_busy;
  logic   [3:0][AW-1:0] rd_addr;
  logic   [1:0][LAT_W-1:0] wr_lat;
  logic   imul_busy, fdiv_busy, fhold_busy;
  logic   pair_raw, clash;
  logic   imul_ld, fdiv_ld, fhold_ld;
  logic   [LAT_W-1:0] imul_val, fdiv_val, fhold_val;

  for (genvar i = 0; i < 2; i++) begin : g_cand
    hz_decode u_dec (.class_i(class_i[i]), .dbl_i(dbl_i[i]), .claim_o(cl[i]));
    assign f_req[i]   = cl[i].fi | cl[i].ff;
    assign unit_ok[i] = !(cl[i].imul && imul_busy) && !(cl[i].fdiv && fdiv_busy)
                        && !(f_req[i] && fhold_busy);
    assign raw[i]     = rd_busy[2*i] | rd_busy[2*i+1];
    assign rd_addr[2*i]   = rs1_i[i];
    assign rd_addr[2*i+1] = rs2_i[i];
    assign wr_lat[i]  = cl[i].lat;
  end

  assign pair_raw = rd_we_i[0] && (rs1_i[1] == rd_i[0] || rs2_i[1] == rd_i[0]);
  assign clash = ({1'b0, cl[0].any_n} + {1'b0, cl[1].any_n} > 3'd2)
               | (cl[0].m & cl[1].m) | (f_req[0] & f_req[1])
               | (cl[0].imul & cl[1].imul) | (cl[0].fdiv & cl[1].fdiv);

  assign issue_o[0] = valid_i[0] && !raw[0] && unit_ok[0];
  assign issue_o[1] = issue_o[0] && valid_i[1] && !raw[1] && unit_ok[1]
                      && !pair_raw && !clash;

  // at most one candidate can claim each unit, so a plain select suffices
  always_comb begin
    imul_ld   = (issue_o[0] && cl[0].imul) || (issue_o[1] && cl[1].imul);
    fdiv_ld   = (issue_o[0] && cl[0].fdiv) || (issue_o[1] && cl[1].fdiv);
    fhold_ld  = (issue_o[0] && cl[0].fhold) || (issue_o[1] && cl[1].fhold);
    imul_val  = (issue_o[0] && cl[0].imul)  ? cl[0].occ - 1'b1 : cl[1].occ - 1'b1;
    fdiv_val  = (issue_o[0] && cl[0].fdiv)  ? cl[0].occ - 1'b1 : cl[1].occ - 1'b1;
    fhold_val = (issue_o[0] && cl[0].fhold) ? cl[0].occ - 1'b1 : cl[1].occ - 1'b1;
  end

  hz_busy_ctr #(.W(LAT_W)) u_imul (.clk_i, .rst_ni, .load_i(imul_ld),
    .load_val_i(imul_val), .busy_o(imul_busy));
  hz_busy_ctr #(.W(LAT_W)) u_fdiv (.clk_i, .rst_ni, .load_i(fdiv_ld),
    .load_val_i(fdiv_val), .busy_o(fdiv_busy));
  hz_busy_ctr #(.W(LAT_W)) u_fhold (.clk_i, .rst_ni, .load_i(fhold_ld),
    .load_val_i(fhold_val), .busy_o(fhold_busy));

  hz_scoreboard #(.NREG(NREG), .AW(AW), .LW(LAT_W), .NWR(2), .NRD(4)) u_sb (
    .clk_i, .rst_ni,
    .wr_en_i   (issue_o & rd_we_i),
    .wr_addr_i (rd_i),
    .wr_lat_i  (wr_lat),
    .rd_addr_i (rd_addr),
    .rd_busy_o (rd_busy)
  );

  AST_PAIR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o[1] |-> issue_o[0]); // R4
  AST_ONE_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o[1] |-> !(cl[0].m && cl[1].m)); // R2
  AST_F_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o[1] |-> !(f_req[0] && f_req[1])); // R3
  AST_IMUL_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imul_busy |-> !imul_ld); // R5
  AST_FDIV_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdiv_busy |-> !fdiv_ld); // R6
  AST_FHOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fhold_busy |-> !((issue_o[0] && f_req[0]) || (issue_o[1] && f_req[1]))); // R7
  AST_UNK_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o[0] && cl[0].any_n == 2'd2) |-> !issue_o[1]); // R8
  AST_SB_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o[0] |-> !(rd_busy[0] || rd_busy[1])); // R9
  AST_PAIR_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o[1] && rd_we_i[0]) |-> (rs1_i[1] != rd_i[0] && rs2_i[1] != rd_i[0])); // R10
endmodule

// File: tb/hz_dual_issue_checker_test.sv
module hz_dual_issue_checker_test;
  localparam int CLK_P = 10;
  localparam int AW    = 5;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [1:0]          valid_i;
  logic [1:0][3:0]     class_i;
  logic [1:0]          dbl_i;
  logic [1:0][AW-1:0]  rs1_i, rs2_i, rd_i;
  logic [1:0]          rd_we_i;
  logic [1:0]          issue_o;

  int n_tests = 0;
  int n_fail  = 0;
  int sb [32];
  int imul_c, fdiv_c, fh_c;

  always #(CLK_P/2) clk_i = ~clk_i;

  hz_dual_issue_checker #(.NREG(32), .AW(AW)) uut (
    .clk_i, .rst_ni, .valid_i, .class_i, .dbl_i,
    .rs1_i, .rs2_i, .rd_i, .rd_we_i, .issue_o
  );

  task automatic dec(input int c, input bit d, output int any_n, output bit m,
                     output bit fi, output bit ff, output bit im, output bit fd,
                     output bit fh, output int lat, output int occ);
    any_n = 0; m = 0; fi = 0; ff = 0; im = 0; fd = 0; fh = 0; lat = 1; occ = 0;
    case (c)
      0: begin any_n = 1; lat = 1; end
      1, 2: begin any_n = 1; lat = 2; end
      3: begin m = 1; lat = 3; end
      4: begin m = 1; lat = 1; end
      5, 6: begin m = 1; lat = 2; end
      7: begin fi = 1; im = d; lat = d ? 7 : 3; occ = d ? 7 : 0; end
      8: begin fi = 1; im = 1; lat = d ? 70 : 38; occ = lat; end
      9: begin fi = 1; lat = 1; end
      10: begin fi = 1; lat = 5; end
      11: begin ff = 1; lat = 2; end
      12: begin ff = 1; lat = 6; end
      13: begin ff = 1; fh = d; lat = d ? 9 : 6; occ = d ? 3 : 0; end
      14: begin ff = 1; fd = 1; lat = d ? 37 : 22; occ = lat; end
      default: begin any_n = 2; m = 1; fi = 1; lat = 1; end
    endcase
  endtask

  // predicts issue vector and advances the model by one edge
  task automatic model_step(output logic [1:0] e);
    int a[2]; bit m[2], fi[2], ff[2], im[2], fd[2], fh[2]; int lat[2], occ[2];
    bit ok[2];
    for (int i = 0; i < 2; i++) begin
      dec(class_i[i], dbl_i[i], a[i], m[i], fi[i], ff[i], im[i], fd[i], fh[i], lat[i], occ[i]);
      ok[i] = valid_i[i] && sb[rs1_i[i]] == 0 && sb[rs2_i[i]] == 0
              && !(im[i] && imul_c != 0) && !(fd[i] && fdiv_c != 0)
              && !((fi[i] || ff[i]) && fh_c != 0);
    end
    e[0] = ok[0];
    e[1] = ok[0] && ok[1] && (a[0] + a[1] <= 2) && !(m[0] && m[1])
           && !((fi[0] || ff[0]) && (fi[1] || ff[1]))
           && !(rd_we_i[0] && (rs1_i[1] == rd_i[0] || rs2_i[1] == rd_i[0]));
    for (int r = 0; r < 32; r++) if (sb[r] > 0) sb[r]--;
    if (imul_c > 0) imul_c--;
    if (fdiv_c > 0) fdiv_c--;
    if (fh_c > 0) fh_c--;
    for (int i = 0; i < 2; i++) begin
      if (e[i]) begin
        if (rd_we_i[i]) sb[rd_i[i]] = lat[i] - 1;
        if (im[i]) imul_c = occ[i] - 1;
        if (fd[i]) fdiv_c = occ[i] - 1;
        if (fh[i]) fh_c = occ[i] - 1;
      end
    end
  endtask

  task automatic step(input string tag, input bit use_exp, input logic [1:0] dexp,
                      input bit chk);
    logic [1:0] me, ex;
    #(CLK_P/4);
    ex = issue_o;
    model_step(me);
    if (use_exp) me = dexp;
    if (chk) begin
      n_tests++;
      if (issue_o !== me) begin
        n_fail++;
        $display("FAIL %s: issue_o=%b expected %b", tag, ex, me);
      end
    end
    @(negedge clk_i);
  endtask

  task automatic setc(input int i, input bit v, input int c, input bit d,
                      input int s1 = 0, input int s2 = 0, input int rd = 0,
                      input bit we = 0);
    valid_i[i] = v; class_i[i] = 4'(c); dbl_i[i] = d;
    rs1_i[i] = AW'(s1); rs2_i[i] = AW'(s2); rd_i[i] = AW'(rd); rd_we_i[i] = we;
  endtask

  task automatic idle(input int n);
    setc(0, 0, 0, 0); setc(1, 0, 0, 0);
    for (int k = 0; k < n; k++) step("idle", 0, 2'b00, 0);
  endtask

  task automatic pair(input string tag, input int c0, input bit d0, input int c1,
                      input bit d1, input logic [1:0] e);
    setc(0, 1, c0, d0); setc(1, 1, c1, d1);
    step(tag, 1, e, 1);
  endtask

  initial begin
    void'($urandom(32'd7321));
    for (int r = 0; r < 32; r++) sb[r] = 0;
    imul_c = 0; fdiv_c = 0; fh_c = 0;
    setc(0, 0, 0, 0); setc(1, 0, 0, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    pair("R11 first pair after reset", 0, 0, 0, 0, 2'b11);
    pair("R1 int+branch", 0, 0, 2, 0, 2'b11);
    pair("R1 icmov+int", 1, 0, 0, 0, 2'b11);
    pair("R2 load+store", 3, 0, 4, 0, 2'b01);
    pair("R2 xfer+fcmov", 5, 0, 6, 0, 2'b01);
    pair("R2 load+int", 3, 0, 0, 0, 2'b11);
    pair("R3 imul+fadd", 7, 0, 12, 0, 2'b01);
    pair("R3 fquick+mthl", 11, 0, 10, 0, 2'b01);
    pair("R3 imul+load", 7, 0, 3, 0, 2'b11);
    pair("R8 unknown+int", 15, 0, 0, 0, 2'b01);
    pair("R8 int+unknown", 0, 0, 15, 0, 2'b01);
    setc(0, 0, 0, 0); setc(1, 1, 0, 0);
    step("R4 older absent", 1, 2'b00, 1);

    // R5: 32-bit divide holds the unit 38 cycles
    setc(0, 1, 8, 0); setc(1, 0, 0, 0);
    step("R5 divide issues", 1, 2'b01, 1);
    setc(0, 1, 7, 0);
    step("R5 32-bit mul not held", 1, 2'b01, 1);
    idle(35);
    setc(0, 1, 7, 1); setc(1, 1, 0, 0);
    step("R5 64-bit mul at cycle 37", 1, 2'b00, 1);
    step("R5 64-bit mul at cycle 38", 1, 2'b11, 1);
    idle(8);

    // R6: double float divide 37 cycles
    setc(0, 1, 14, 1); setc(1, 0, 0, 0);
    step("R6 fdiv issues", 1, 2'b01, 1);
    idle(35);
    setc(0, 1, 14, 0);
    step("R6 fdiv at cycle 36", 1, 2'b00, 1);
    step("R6 fdiv at cycle 37", 1, 2'b01, 1);
    idle(25);

    // R7: double multiply holds float half 3 cycles
    setc(0, 1, 13, 1);
    step("R7 fmul.d issues", 1, 2'b01, 1);
    setc(0, 1, 12, 0);
    step("R7 fadd cycle 1", 1, 2'b00, 1);
    setc(0, 1, 9, 0);
    step("R7 mfhl cycle 2", 1, 2'b00, 1);
    setc(0, 1, 12, 0);
    step("R7 fadd cycle 3", 1, 2'b01, 1);
    idle(4);

    // R9: load latency 3
    setc(0, 1, 3, 0, 0, 0, 5, 1);
    step("R9 load issues", 1, 2'b01, 1);
    setc(0, 1, 0, 0, 5, 0);
    step("R9 use at +1", 1, 2'b00, 1);
    step("R9 use at +2", 1, 2'b00, 1);
    step("R9 use at +3", 1, 2'b01, 1);

    // R10: same-cycle dependency
    setc(0, 1, 0, 0, 0, 0, 3, 1); setc(1, 1, 0, 0, 1, 3);
    step("R10 pair raw", 1, 2'b01, 1);
    idle(2);

    // mixed random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < 2; i++)
        setc(i, ($urandom % 8) != 0, $urandom % 16, $urandom % 2,
             $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 2);
      step("R4 random pair", 0, 2'b00, 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: issue_o=%b expected completion", issue_o);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule